// File: doc/BRIEF.md
# Vector Register Gather Unit

This block performs an indexed gather across a vector register file that it holds in block RAM. Each destination element `i` gets the element of a source register group picked by an index. The index can come from three places: a second register group read at the data element width, one scalar shared by every element, or a second register group always read as 16-bit values. Any index at or above `vlmax` yields zero for that element.

A caller loads and reads the register file through a 64-bit row port while the unit is idle. It then pulses `start` together with the operation fields. The unit works through elements `vstart` to `vl-1` one at a time. If masking is enabled, it skips elements whose bit in register 0 is clear. The mask is copied from register 0 before the first write, so a destination group that overlaps register 0 does not change which elements are active.

When the operation ends, the unit raises a one-cycle `done` pulse. In the same cycle it pulses the requests that clear the caller's start index and mark the vector state dirty.

Top module: `gather_unit`

## Requirements
- R1: With `mode`=0 (code 3 behaves the same), the index for element i is element i of the group based at `vs1`, read at the data width, and `vd[i]` becomes element `index` of the group based at `vs2`.
- R2: With `mode`=2, indices are read as 16-bit elements (element i at byte `vs1*VLENB + 2*i`) whatever the data width is.
- R3: An index that is greater than or equal to `vlmax`, taken as an unsigned 64-bit value, writes zero to that element. An index with bit 63 set therefore writes zero.
- R4: With `mode`=1, the source element selected by `scal_idx` is read once and written to every active destination element. If `scal_idx` >= `vlmax`, every active element is written with zero.
- R5: With `use_mask`=1, element i is written only if bit i%8 of byte i/8 of register 0 is set, and the other elements keep their old value. With `use_mask`=0, all elements in the range are written.
- R6: The mask is captured before any element is written, so a destination group that covers register 0 still uses the mask bits held at `start`.
- R7: Only elements with `vstart` <= i < `vl` are written. When `vstart` >= `vl`, nothing in the register file changes.
- R8: `done`, `vstart_clr` and `dirty_set` are one-cycle pulses issued together. `busy` rises the cycle after an accepted `start` and falls in the cycle that `done` is high.
- R9: `start` is ignored while `busy` is high. No second operation runs and no second `done` is raised.
- R10: `sew` code k selects 8<<k bit elements. Element j of a group based at register r occupies the bytes starting at `r*VLENB + j*(1<<k)`, little-endian.
- R11: Host row k holds bytes 8k..8k+7, with byte b in bits `8*(b%8)`. `host_we` writes a row only while `busy` is low. `host_rdata` shows the row at `host_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| mode | input | 2 | Index source: 0 vector, 1 scalar, 2 16-bit vector |
| sew | input | 2 | Element width code (8<<sew bits) |
| use_mask | input | 1 | Enable masking by register 0 |
| vd | input | $clog2(NREG) | Destination group base register |
| vs2 | input | $clog2(NREG) | Source data group base register |
| vs1 | input | $clog2(NREG) | Index group base register |
| scal_idx | input | 64 | Scalar index |
| vl | input | $clog2(VLEN)+1 | End element (exclusive) |
| vstart | input | $clog2(VLEN)+1 | First element |
| vlmax | input | $clog2(VLEN)+1 | Elements in a source group |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| vstart_clr | output | 1 | Pulse requesting that the start index be cleared |
| dirty_set | output | 1 | Pulse requesting that the vector state be marked dirty |
| host_we | input | 1 | Row write enable (idle only) |
| host_addr | input | $clog2(NREG*VLEN/64) | Row address |
| host_wdata | input | 64 | Row write data |
| host_rdata | output | 64 | Row read data, one cycle after the address |

## Verification
The assertions assume that the caller holds `vl <= vlmax`, that each addressed group fits inside the register file, and that indices for the 16-bit form fit in their group. Under those conditions the engine writes only while busy and its completion pulses line up. The stimulus places all groups at fixed, non-overlapping bases two registers wide and derives `vl` from `vlmax`. Overlap occurs only in the dedicated mask-snapshot case, which puts the destination on register 0. The host port is used only while the unit is idle, apart from one deliberate write during a busy operation, which is expected to be dropped.

// File: rtl/gather_pkg.sv
package gather_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MASK, ST_SFETCH, ST_SWAIT, ST_ELEM, ST_SRC, ST_WR
  } gst_e;

  localparam logic [1:0] MODE_SCALAR = 2'd1;
  localparam logic [1:0] MODE_IDX16  = 2'd2;

  // zero-extended element of width 8<<lg starting at byte lane of a 64-bit row
  function automatic logic [63:0] pick_elem(input logic [63:0] row,
                                            input logic [2:0]  lane,
                                            input logic [1:0]  lg);
    logic [63:0] s;
    s = row >> {lane, 3'b000};
    case (lg)
      2'd0:    return {56'd0, s[7:0]};
      2'd1:    return {48'd0, s[15:0]};
      2'd2:    return {32'd0, s[31:0]};
      default: return s;
    endcase
  endfunction

  function automatic logic [7:0] lane_en(input logic [1:0] lg);
    case (lg)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/gather_vrf.sv
module gather_vrf #(
  parameter int ROWS = 64,
  localparam int RAW = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [7:0]     be,
  input  logic [RAW-1:0] addr,
  input  logic [63:0]    wdata,
  output logic [63:0]    rdata
);
  logic [63:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 8; b++) begin
        if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
#(
  parameter int NREG = 32,
  parameter int VLEN = 128,
  localparam int RW   = $clog2(NREG),
  localparam int VLENB = VLEN / 8,
  localparam int VBW  = $clog2(VLENB),
  localparam int BAW  = RW + VBW,
  localparam int RAW  = BAW - 3,
  localparam int CNTW = $clog2(VLEN) + 1,
  localparam int RPR  = VLEN / 64,
  localparam int MCW  = $clog2(RPR + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [1:0]      sew,
  input  logic            use_mask,
  input  logic [RW-1:0]   vd,
  input  logic [RW-1:0]   vs2,
  input  logic [RW-1:0]   vs1,
  input  logic [63:0]     scal_idx,
  input  logic [CNTW-1:0] vl,
  input  logic [CNTW-1:0] vstart,
  input  logic [CNTW-1:0] vlmax,
  input  logic [63:0]     rdata,
  output logic            ram_we,
  output logic [7:0]      ram_be,
  output logic [RAW-1:0]  ram_addr,
  output logic [63:0]     ram_wdata,
  output logic            busy,
  output logic            done,
  output logic            vstart_clr,
  output logic            dirty_set
);
  gst_e            state_q;
  logic [1:0]      mode_q, sewlog_q;
  logic            mask_en_q;
  logic [RW-1:0]   vd_q, vs2_q, vs1_q;
  logic [63:0]     scal_q, held_q;
  logic [CNTW-1:0] vl_q, vlmax_q, i_q;
  logic [MCW-1:0]  mcnt_q;
  logic [VLEN-1:0] mask_q;
  logic [2:0]      lane_q;
  logic            oob_q;

  logic            is_scalar;
  logic [1:0]      ilog;
  logic [BAW-1:0]  idx_byte, vd_byte, src_byte, sc_byte;
  logic [63:0]     got_idx, wval;
  logic            idx_oob, sc_oob, in_range, active;

  assign is_scalar = (mode_q == MODE_SCALAR);
  assign ilog      = (mode_q == MODE_IDX16) ? 2'd1 : sewlog_q;
  assign idx_byte  = {vs1_q, {VBW{1'b0}}} + (BAW'(i_q) << ilog);
  assign vd_byte   = {vd_q,  {VBW{1'b0}}} + (BAW'(i_q) << sewlog_q);
  assign got_idx   = pick_elem(rdata, lane_q, ilog);
  assign idx_oob   = got_idx >= 64'(vlmax_q);
  assign src_byte  = {vs2_q, {VBW{1'b0}}} + (BAW'(got_idx) << sewlog_q);
  assign sc_oob    = scal_q >= 64'(vlmax_q);
  assign sc_byte   = {vs2_q, {VBW{1'b0}}} + (BAW'(scal_q) << sewlog_q);
  assign in_range  = i_q < vl_q;
  assign active    = in_range && (!mask_en_q || mask_q[i_q[CNTW-2:0]]);

  // read/write port steering per state
  always_comb begin
    ram_addr = '0;
    ram_we   = 1'b0;
    wval     = '0;
    case (state_q)
      ST_MASK:   ram_addr = RAW'(mcnt_q);
      ST_SFETCH,
      ST_SWAIT:  ram_addr = sc_byte[BAW-1:3];
      ST_ELEM: begin
        if (is_scalar) begin
          ram_addr = vd_byte[BAW-1:3];
          ram_we   = active;
          wval     = held_q;
        end else begin
          ram_addr = idx_byte[BAW-1:3];
        end
      end
      ST_SRC:    ram_addr = src_byte[BAW-1:3];
      ST_WR: begin
        ram_addr = vd_byte[BAW-1:3];
        ram_we   = 1'b1;
        wval     = oob_q ? 64'd0 : pick_elem(rdata, lane_q, sewlog_q);
      end
      default:   ram_addr = '0;
    endcase
  end

  assign ram_wdata = wval << {vd_byte[2:0], 3'b000};
  assign ram_be    = lane_en(sewlog_q) << vd_byte[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      vstart_clr <= 1'b0;
      dirty_set  <= 1'b0;
      mode_q     <= '0;
      sewlog_q   <= '0;
      mask_en_q  <= 1'b0;
      vd_q       <= '0;
      vs2_q      <= '0;
      vs1_q      <= '0;
      scal_q     <= '0;
      held_q     <= '0;
      vl_q       <= '0;
      vlmax_q    <= '0;
      i_q        <= '0;
      mcnt_q     <= '0;
      mask_q     <= '0;
      lane_q     <= '0;
      oob_q      <= 1'b0;
    end else begin
      done       <= 1'b0;
      vstart_clr <= 1'b0;
      dirty_set  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= mode;
            sewlog_q  <= sew;
            mask_en_q <= use_mask;
            vd_q      <= vd;
            vs2_q     <= vs2;
            vs1_q     <= vs1;
            scal_q    <= scal_idx;
            vl_q      <= vl;
            vlmax_q   <= vlmax;
            i_q       <= vstart;
            mcnt_q    <= '0;
            busy      <= 1'b1;
            state_q   <= ST_MASK;
          end
        end
        ST_MASK: begin
          if (mcnt_q != '0) mask_q[(int'(mcnt_q) - 1) * 64 +: 64] <= rdata;
          if (int'(mcnt_q) == RPR) state_q <= is_scalar ? ST_SFETCH : ST_ELEM;
          else mcnt_q <= mcnt_q + 1'b1;
        end
        ST_SFETCH: begin
          if (sc_oob) begin
            held_q  <= '0;
            state_q <= ST_ELEM;
          end else begin
            state_q <= ST_SWAIT;
          end
        end
        ST_SWAIT: begin
          held_q  <= pick_elem(rdata, sc_byte[2:0], sewlog_q);
          state_q <= ST_ELEM;
        end
        ST_ELEM: begin
          if (!in_range) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            vstart_clr <= 1'b1;
            dirty_set  <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (!active || is_scalar) begin
            i_q <= i_q + 1'b1;
          end else begin
            lane_q  <= idx_byte[2:0];
            state_q <= ST_SRC;
          end
        end
        ST_SRC: begin
          oob_q   <= idx_oob;
          lane_q  <= src_byte[2:0];
          state_q <= ST_WR;
        end
        ST_WR: begin
          i_q     <= i_q + 1'b1;
          state_q <= ST_ELEM;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gather_unit.sv
module gather_unit #(
  parameter int NREG = 32,
  parameter int VLEN = 128,
  localparam int RW   = $clog2(NREG),
  localparam int ROWS = NREG * VLEN / 64,
  localparam int RAW  = $clog2(ROWS),
  localparam int CNTW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [1:0]      sew,
  input  logic            use_mask,
  input  logic [RW-1:0]   vd,
  input  logic [RW-1:0]   vs2,
  input  logic [RW-1:0]   vs1,
  input  logic [63:0]     scal_idx,
  input  logic [CNTW-1:0] vl,
  input  logic [CNTW-1:0] vstart,
  input  logic [CNTW-1:0] vlmax,
  output logic            busy,
  output logic            done,
  output logic            vstart_clr,
  output logic            dirty_set,
  input  logic            host_we,
  input  logic [RAW-1:0]  host_addr,
  input  logic [63:0]     host_wdata,
  output logic [63:0]     host_rdata
);
  logic           eng_we;
  logic [7:0]     eng_be;
  logic [RAW-1:0] eng_addr;
  logic [63:0]    eng_wdata;
  logic [63:0]    ram_rdata;

  gather_ctrl #(.NREG(NREG), .VLEN(VLEN)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sew(sew),
    .use_mask(use_mask), .vd(vd), .vs2(vs2), .vs1(vs1),
    .scal_idx(scal_idx), .vl(vl), .vstart(vstart), .vlmax(vlmax),
    .rdata(ram_rdata), .ram_we(eng_we), .ram_be(eng_be),
    .ram_addr(eng_addr), .ram_wdata(eng_wdata), .busy(busy),
    .done(done), .vstart_clr(vstart_clr), .dirty_set(dirty_set)
  );

  gather_vrf #(.ROWS(ROWS)) u_vrf (
    .clk(clk),
    .we(busy ? eng_we : host_we),
    .be(busy ? eng_be : 8'hFF),
    .addr(busy ? eng_addr : host_addr),
    .wdata(busy ? eng_wdata : host_wdata),
    .rdata(ram_rdata)
  );

  assign host_rdata = ram_rdata;
endmodule

// File: rtl/gather_unit_chk.sv
module gather_unit_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic vstart_clr,
  input logic dirty_set,
  input logic eng_we
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_flags_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (vstart_clr && dirty_set));
  assert_flags_need_done_R8: assert property (@(posedge clk) disable iff (rst)
    (vstart_clr || dirty_set) |-> done);
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_write_in_op_R7: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> busy);
endmodule

bind gather_unit gather_unit_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .vstart_clr(vstart_clr), .dirty_set(dirty_set), .eng_we(eng_we)
);

// File: tb/gather_unit_tb_top.sv
`timescale 1ns/1ps
module gather_unit_tb_top;
  localparam int NREG = 32;
  localparam int VLEN = 128;
  localparam int VLENB = VLEN / 8;
  localparam int NBYTE = NREG * VLENB;
  localparam int ROWS = NBYTE / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = '0, sew = '0;
  logic use_mask = 1'b0;
  logic [4:0] vd = '0, vs2 = '0, vs1 = '0;
  logic [63:0] scal_idx = '0;
  logic [7:0] vl = '0, vstart = '0, vlmax = '0;
  logic busy, done, vstart_clr, dirty_set;
  logic host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;

  int checks = 0;
  int fails = 0;
  logic [7:0] mdl [NBYTE];

  always #4 clk = ~clk;

  gather_unit #(.NREG(NREG), .VLEN(VLEN)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sew(sew),
    .use_mask(use_mask), .vd(vd), .vs2(vs2), .vs1(vs1),
    .scal_idx(scal_idx), .vl(vl), .vstart(vstart), .vlmax(vlmax),
    .busy(busy), .done(done), .vstart_clr(vstart_clr),
    .dirty_set(dirty_set), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10: element j of group at register r, width w bytes, little-endian
  function automatic logic [63:0] mget(int r, int j, int w);
    logic [63:0] v;
    v = '0;
    for (int k = 0; k < w; k++) v[8*k +: 8] = mdl[r*VLENB + j*w + k];
    return v;
  endfunction

  task automatic mset(int r, int j, int w, logic [63:0] v);
    for (int k = 0; k < w; k++) mdl[r*VLENB + j*w + k] = v[8*k +: 8];
  endtask

  task automatic fill(int seed, int md, int sl, int vlm);
    int iw;
    logic [63:0] v;
    for (int b = 0; b < NBYTE; b++) mdl[b] = 8'(((b * 37 + seed * 11) ^ (b >> 3)) & 255);
    if (md != 1) begin
      iw = (md == 2) ? 2 : (1 << sl);
      for (int j = 0; j < vlm; j++) begin
        v = 64'((j * 5 + seed) % (vlm + 3));
        if (j == 1 && iw == 8) v = 64'h8000_0000_0000_0001;
        if (j == 2 && iw == 2) v = 64'h8001;
        mset(16, j, iw, v);
      end
    end
  endtask

  // R11: host rows carry bytes 8k..8k+7
  task automatic load_all();
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      host_we = 1'b1;
      host_addr = 6'(r);
      for (int k = 0; k < 8; k++) host_wdata[8*k +: 8] = mdl[8*r + k];
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [63:0] e;
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      host_addr = 6'(r);
      @(negedge clk);
      for (int k = 0; k < 8; k++) e[8*k +: 8] = mdl[8*r + k];
      chk(host_rdata === e, $sformatf("%s row %0d", tag, r), host_rdata, e);
    end
  endtask

  task automatic model_op(int md, int sl, bit msk, int rd, int r2, int r1,
                          logic [63:0] sc, int vln, int vst, int vlm);
    logic [VLEN-1:0] mbits;
    logic [63:0] idx, val, sval;
    int w, iw;
    w = 1 << sl;
    iw = (md == 2) ? 2 : w;
    for (int i = 0; i < VLEN; i++) mbits[i] = mdl[i / 8][i % 8];
    sval = (sc < 64'(vlm)) ? mget(r2, int'(sc), w) : 64'd0;
    for (int i = vst; i < vln; i++) begin
      if (msk && !mbits[i]) continue;
      if (md == 1) val = sval;
      else begin
        idx = mget(r1, i, iw);
        val = (idx < 64'(vlm)) ? mget(r2, int'(idx), w) : 64'd0;
      end
      mset(rd, i, w, val);
    end
  endtask

  task automatic run_op(int md, int sl, bit msk, int rd, int r2, int r1,
                        logic [63:0] sc, int vln, int vst, int vlm,
                        input string tag, bit poke);
    int n;
    bit extra;
    load_all();
    model_op(md, sl, msk, rd, r2, r1, sc, vln, vst, vlm);
    @(negedge clk);
    start = 1'b1; mode = 2'(md); sew = 2'(sl); use_mask = msk;
    vd = 5'(rd); vs2 = 5'(r2); vs1 = 5'(r1); scal_idx = sc;
    vl = 8'(vln); vstart = 8'(vst); vlmax = 8'(vlm);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: second start and a host write while busy must both be dropped
      start = 1'b1; vd = 5'd28;
      host_we = 1'b1; host_addr = 6'd63; host_wdata = '1;
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, {tag, " R8 done seen"}, 64'(done), 64'd1);
    chk(vstart_clr === 1'b1 && dirty_set === 1'b1 && busy === 1'b0,
        {tag, " R8 flags with done"}, {61'd0, vstart_clr, dirty_set, busy}, 64'd6);
    @(negedge clk);
    chk(done === 1'b0 && vstart_clr === 1'b0, {tag, " R8 one-cycle pulse"},
        64'(done), 64'd0);
    if (poke) begin
      extra = 1'b0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (done === 1'b1 || busy === 1'b1) extra = 1'b1;
      end
      chk(!extra, {tag, " R9 no second operation"}, 64'(extra), 64'd0);
    end
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed, vlm;
    string tg;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && dirty_set === 1'b0,
        "R8 reset state", {61'd0, busy, done, dirty_set}, 64'd0);

    // sweep: three index sources x four widths (R10) x mask on/off x two ranges
    for (int md = 0; md < 3; md++)
      for (int sl = 0; sl < 4; sl++)
        for (int msk = 0; msk < 2; msk++)
          for (int vr = 0; vr < 2; vr++) begin
            seed = md * 16 + sl * 4 + msk * 2 + vr + 1;
            vlm = 32 >> sl;
            fill(seed, md, sl, vlm);
            tg = (md == 0) ? "R1/R3/R10" : (md == 1) ? "R4/R10" : "R2/R3/R10";
            if (msk != 0) tg = {tg, "/R5"};
            if (vr != 0) tg = {tg, "/R7"};
            run_op(md, sl, msk[0], 24, 8, 16,
                   (vr != 0) ? 64'(vlm + 1) : 64'(seed % vlm),
                   (vr != 0) ? vlm - 1 : vlm, vr, vlm, tg, 1'b0);
          end

    // R3/R4: scalar index with bit 63 set writes zeros
    fill(77, 1, 2, 8);
    run_op(1, 2, 1'b0, 24, 8, 16, 64'h8000_0000_0000_0003, 8, 0, 8, "R3/R4 top bit", 1'b0);

    // R6: destination covers register 0, mask taken before writes
    fill(91, 0, 0, 32);
    run_op(0, 0, 1'b1, 0, 8, 16, 64'd0, 32, 0, 32, "R6 snapshot", 1'b0);

    // R7: vstart equal to vl changes nothing
    fill(55, 0, 1, 16);
    run_op(0, 1, 1'b0, 24, 8, 16, 64'd0, 5, 5, 16, "R7 empty range", 1'b0);

    // R9/R11: start and host write while busy are ignored
    fill(33, 2, 0, 32);
    run_op(2, 0, 1'b0, 24, 8, 16, 64'd0, 32, 0, 32, "R9/R11 busy", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule